// File: doc/BRIEF.md
# Semaphore-Counted Descriptor Chain DMA Channel

This block is one DMA channel that sequences a linked list of command descriptors held in memory. Software places the address of the first descriptor in a next-command register. It then adds a count to the channel's semaphore. While that count is above zero, the channel fetches a descriptor, runs a stand-in data phase of fixed length and completes the command. If the command asks for it, the channel then lowers the count by one. It follows the chain pointer while the chain bit is set and the count is still nonzero.

Each descriptor is three words at consecutive word addresses. The first word is the address of the next descriptor. The second word is a flags word: bit 0 is chain, bit 1 is decrement-count, bit 2 is interrupt-on-complete, and bits 31:16 hold a byte count that the stand-in data phase ignores. The third word is a buffer address. Software controls the channel through a control word that has separate set and clear alias addresses. That word carries a clock-gate bit, a self-clearing channel reset bit, an interrupt enable bit and a completion status bit.

Top module: `sema_chain_dma`

## Requirements
- R1: The channel leaves idle only when the semaphore count is nonzero, a nonzero semaphore write has armed it, and the gate is clear. It then fetches from the next-command register. It issues no new descriptor fetch once the count has reached zero.
- R2: At command completion the count drops by one only when flags bit 1 of that command is set. Otherwise the count is unchanged and the chain continues.
- R3: When flags bit 0 is set, the next-command register takes descriptor word 0 at completion and the next fetch uses that address. A command with bit 0 clear ends the chain and disarms the channel, even if count remains.
- R4: A write to the semaphore register (offset 4) adds the written low bits to the count. Reading offset 4 returns the count. A write of zero does not arm the channel. An add and a decrement in the same cycle give the written value minus one.
- R5: Control bit 0 (gate) keeps the channel idle while set. Setting it during a command returns the channel to idle on the following cycle. The semaphore and next-command register are left unchanged, so clearing the gate reruns the abandoned command.
- R6: Writing ones at offset 1 sets control bits and writing ones at offset 2 clears them. Zero bits are left alone. Offset 0 reads {status, enable, reset, gate} in bits 3..0. Offset 3 is the next-command register.
- R7: Completing a command with flags bit 2 set raises status (control bit 3). Only the clear alias lowers status. The irq output is status AND enable (control bit 2).
- R8: Setting control bit 1 aborts any command and clears the count, the status bit and the armed state. The reset bit reads back zero again on the next cycle.
- R9: A descriptor at address A is read as A, A+4, A+8 on consecutive mem_req cycles, with mem_rdata valid one cycle after each request. A single command keeps chan_busy high for 4 + XFER_CYC + 1 cycles, and no request is made while idle.
- R10: After reset the control word, count and next-command register read zero, and irq, mem_req and chan_busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| host_addr | input | 3 | register word offset |
| host_we | input | 1 | register write strobe |
| host_wdata | input | DATA_W | register write data |
| host_rdata | output | DATA_W | register read data (combinational on host_addr) |
| mem_req | output | 1 | descriptor word read request |
| mem_addr | output | DATA_W | byte address of the requested word |
| mem_rdata | input | DATA_W | word returned one cycle after mem_req |
| irq | output | 1 | completion interrupt |
| chan_busy | output | 1 | channel is fetching or executing a command |

## Verification
The bench targets chains that stop because the count runs out while the chain bit is still set. A design that ignored the count would run past the expected end and be caught by the fetch tally. It also targets commands that carry no decrement flag; a design that always decremented would stop one command early. A gate raised in the middle of a data phase must leave the count and pointer intact, or the rerun would skip or repeat work. A semaphore add is swept across every cycle of a running command, so an add landing on the completion cycle must still give the exact net count. A wrong result there loses or adds a command. Reset in the middle of a run must clear the count and must not restart.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_F0,
        ST_F1,
        ST_F2,
        ST_F3,
        ST_XFER,
        ST_CMPL
    } seq_st_e;

    // flags word bit positions
    localparam int FLG_CHAIN = 0;
    localparam int FLG_DEC   = 1;
    localparam int FLG_IRQ   = 2;
    localparam int FLG_W     = 3;

    // control word bit positions
    localparam int CB_GATE = 0;
    localparam int CB_RST  = 1;
    localparam int CB_IEN  = 2;
    localparam int CB_STAT = 3;

    // register word offsets
    localparam int          RA_W    = 3;
    localparam logic [2:0]  RA_CTRL = 3'd0;
    localparam logic [2:0]  RA_SET  = 3'd1;
    localparam logic [2:0]  RA_CLR  = 3'd2;
    localparam logic [2:0]  RA_NEXT = 3'd3;
    localparam logic [2:0]  RA_SEMA = 3'd4;

endpackage

// File: rtl/sdma_xfer.sv
module sdma_xfer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } xf_t;

    xf_t x_d, x_q;

    assign done = x_q.active && (x_q.cnt == '0);

    always_comb begin
        x_d = x_q;
        if (x_q.active) begin
            if (x_q.cnt == '0) begin
                x_d.active = 1'b0;
            end else begin
                x_d.cnt = x_q.cnt - 1'b1;
            end
        end
        if (start) begin
            x_d.active = 1'b1;
            x_d.cnt    = CNT_W'(LAT - 1);
        end
        if (abort) begin
            x_d.active = 1'b0;
            x_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   host_addr,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dec_req,
    input  logic              irq_req,
    input  logic              nxt_upd,
    input  logic [DATA_W-1:0] nxt_val,
    input  logic              chain_end,
    output logic              gate,
    output logic              srst,
    output logic              ien,
    output logic              stat,
    output logic              run,
    output logic [SEMA_W-1:0] sema,
    output logic [DATA_W-1:0] nxt
);
    typedef struct packed {
        logic              gate;
        logic              srst;
        logic              ien;
        logic              stat;
        logic              run;
        logic [SEMA_W-1:0] sema;
        logic [DATA_W-1:0] nxt;
    } rg_t;

    rg_t r_d, r_q;

    logic              wr_set, wr_clr, wr_next, wr_sema;
    logic [SEMA_W-1:0] sema_add;
    logic              sema_sub;

    assign wr_set  = host_we && (host_addr == RA_SET);
    assign wr_clr  = host_we && (host_addr == RA_CLR);
    assign wr_next = host_we && (host_addr == RA_NEXT);
    assign wr_sema = host_we && (host_addr == RA_SEMA);

    always_comb begin
        r_d      = r_q;
        sema_add = (wr_sema && !r_q.srst) ? host_wdata[SEMA_W-1:0] : '0;
        sema_sub = dec_req && (r_q.sema != '0);

        if (wr_clr) begin
            if (host_wdata[CB_GATE]) r_d.gate = 1'b0;
            if (host_wdata[CB_RST])  r_d.srst = 1'b0;
            if (host_wdata[CB_IEN])  r_d.ien  = 1'b0;
            if (host_wdata[CB_STAT]) r_d.stat = 1'b0;
        end
        if (wr_set) begin
            if (host_wdata[CB_GATE]) r_d.gate = 1'b1;
            if (host_wdata[CB_RST])  r_d.srst = 1'b1;
            if (host_wdata[CB_IEN])  r_d.ien  = 1'b1;
        end

        if (nxt_upd) r_d.nxt = nxt_val;
        if (wr_next) r_d.nxt = host_wdata;

        r_d.sema = r_q.sema + sema_add - SEMA_W'(sema_sub);

        if (chain_end)         r_d.run = 1'b0;
        if (sema_add != '0)    r_d.run = 1'b1;
        if (irq_req)           r_d.stat = 1'b1;

        if (r_q.srst) begin
            r_d.sema = '0;
            r_d.stat = 1'b0;
            r_d.run  = 1'b0;
            if (!(wr_set && host_wdata[CB_RST])) begin
                r_d.srst = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RA_CTRL: begin
                host_rdata[CB_GATE] = r_q.gate;
                host_rdata[CB_RST]  = r_q.srst;
                host_rdata[CB_IEN]  = r_q.ien;
                host_rdata[CB_STAT] = r_q.stat;
            end
            RA_NEXT: host_rdata = r_q.nxt;
            RA_SEMA: host_rdata[SEMA_W-1:0] = r_q.sema;
            default: host_rdata = '0;
        endcase
    end

    assign gate = r_q.gate;
    assign srst = r_q.srst;
    assign ien  = r_q.ien;
    assign stat = r_q.stat;
    assign run  = r_q.run;
    assign sema = r_q.sema;
    assign nxt  = r_q.nxt;

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
    import sdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate,
    input  logic              srst,
    input  logic              run,
    input  logic [SEMA_W-1:0] sema,
    input  logic [DATA_W-1:0] nxt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              xfer_done,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    output logic              busy,
    output logic              xfer_start,
    output logic              xfer_abort,
    output logic              dec_req,
    output logic              irq_req,
    output logic              nxt_upd,
    output logic [DATA_W-1:0] nxt_val,
    output logic              chain_end
);
    localparam logic [DATA_W-1:0] WORD1_OFS = DATA_W'(4);
    localparam logic [DATA_W-1:0] WORD2_OFS = DATA_W'(8);

    typedef struct packed {
        seq_st_e           st;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] w_next;
        logic [FLG_W-1:0]  flags;
    } sq_t;

    sq_t s_d, s_q;
    logic [SEMA_W-1:0] left;

    always_comb begin
        s_d        = s_q;
        mem_req    = 1'b0;
        mem_addr   = '0;
        xfer_start = 1'b0;
        xfer_abort = 1'b0;
        dec_req    = 1'b0;
        irq_req    = 1'b0;
        nxt_upd    = 1'b0;
        nxt_val    = '0;
        chain_end  = 1'b0;
        left       = sema - SEMA_W'(s_q.flags[FLG_DEC]);

        case (s_q.st)
            ST_IDLE: begin
                if (run && (sema != '0) && !gate && !srst) begin
                    s_d.st   = ST_F0;
                    s_d.base = nxt;
                end
            end
            ST_F0: begin
                mem_req  = 1'b1;
                mem_addr = s_q.base;
                s_d.st   = ST_F1;
            end
            ST_F1: begin
                s_d.w_next = mem_rdata;
                mem_req    = 1'b1;
                mem_addr   = s_q.base + WORD1_OFS;
                s_d.st     = ST_F2;
            end
            ST_F2: begin
                s_d.flags = mem_rdata[FLG_W-1:0];
                mem_req   = 1'b1;
                mem_addr  = s_q.base + WORD2_OFS;
                s_d.st    = ST_F3;
            end
            ST_F3: begin
                xfer_start = 1'b1;
                s_d.st     = ST_XFER;
            end
            ST_XFER: begin
                if (xfer_done) s_d.st = ST_CMPL;
            end
            ST_CMPL: begin
                dec_req = s_q.flags[FLG_DEC];
                irq_req = s_q.flags[FLG_IRQ];
                if (s_q.flags[FLG_CHAIN]) begin
                    nxt_upd = 1'b1;
                    nxt_val = s_q.w_next;
                    if (left != '0) begin
                        s_d.st   = ST_F0;
                        s_d.base = s_q.w_next;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end else begin
                    chain_end = 1'b1;
                    s_d.st    = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        // gate or channel reset abandons whatever is in flight
        if ((s_q.st != ST_IDLE) && (gate || srst)) begin
            s_d.st     = ST_IDLE;
            mem_req    = 1'b0;
            mem_addr   = '0;
            xfer_start = 1'b0;
            xfer_abort = 1'b1;
            dec_req    = 1'b0;
            irq_req    = 1'b0;
            nxt_upd    = 1'b0;
            nxt_val    = '0;
            chain_end  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != ST_IDLE);

endmodule

// File: rtl/sema_chain_dma.sv
module sema_chain_dma
    import sdma_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SEMA_W   = 8,
    parameter int XFER_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq,
    output logic              chan_busy
);
    logic              ctl_gate, ctl_srst, ctl_ien, ctl_stat, ctl_run;
    logic [SEMA_W-1:0] ctl_sema;
    logic [DATA_W-1:0] ctl_nxt;
    logic              sq_dec, sq_irq, sq_nxt_upd, sq_chain_end;
    logic [DATA_W-1:0] sq_nxt_val;
    logic              xf_start, xf_abort, xf_done;

    sdma_regs #(.DATA_W(DATA_W), .SEMA_W(SEMA_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dec_req    (sq_dec),
        .irq_req    (sq_irq),
        .nxt_upd    (sq_nxt_upd),
        .nxt_val    (sq_nxt_val),
        .chain_end  (sq_chain_end),
        .gate       (ctl_gate),
        .srst       (ctl_srst),
        .ien        (ctl_ien),
        .stat       (ctl_stat),
        .run        (ctl_run),
        .sema       (ctl_sema),
        .nxt        (ctl_nxt)
    );

    sdma_seq #(.DATA_W(DATA_W), .SEMA_W(SEMA_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate       (ctl_gate),
        .srst       (ctl_srst),
        .run        (ctl_run),
        .sema       (ctl_sema),
        .nxt        (ctl_nxt),
        .mem_rdata  (mem_rdata),
        .xfer_done  (xf_done),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .busy       (chan_busy),
        .xfer_start (xf_start),
        .xfer_abort (xf_abort),
        .dec_req    (sq_dec),
        .irq_req    (sq_irq),
        .nxt_upd    (sq_nxt_upd),
        .nxt_val    (sq_nxt_val),
        .chain_end  (sq_chain_end)
    );

    sdma_xfer #(.LAT(XFER_CYC)) i_xfer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (xf_start),
        .abort (xf_abort),
        .done  (xf_done)
    );

    assign irq = ctl_stat && ctl_ien;

endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
    parameter int SEMA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [2:0]        host_addr,
    input logic              chan_busy,
    input logic              mem_req,
    input logic              irq,
    input logic              gate,
    input logic              srst,
    input logic              stat,
    input logic [SEMA_W-1:0] sema
);
    logic sema_wr;
    assign sema_wr = host_we && (host_addr == 3'd4);

    p_idle_no_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_busy |-> !mem_req);

    p_zero_stays_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_busy && (sema == '0)) |=> !chan_busy);

    p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sema_wr |=> ((sema == $past(sema)) || ((sema + 1'b1) == $past(sema)) || (sema == '0)));

    p_gate_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> !chan_busy);

    p_irq_needs_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat);

    p_rst_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> ((sema == '0) && !stat && !chan_busy));

endmodule

bind sema_chain_dma sdma_chk #(.SEMA_W(SEMA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_addr (host_addr),
    .chan_busy (chan_busy),
    .mem_req   (mem_req),
    .irq       (irq),
    .gate      (ctl_gate),
    .srst      (ctl_srst),
    .stat      (ctl_stat),
    .sema      (ctl_sema)
);

// File: tb/test_sema_chain_dma.sv
module test_sema_chain_dma;

    localparam int DW   = 32;
    localparam int XCYC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    host_addr = '0;
    logic          host_we = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          mem_req;
    logic [DW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          irq;
    logic          chan_busy;

    int n_chk = 0;
    int n_err = 0;
    int n_starts = 0;
    int n_req = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mem [32];
    logic [DW-1:0] req_log [64];

    always #10 clk = ~clk;  // 50 MHz

    sema_chain_dma #(.DATA_W(DW), .SEMA_W(8), .XFER_CYC(XCYC)) i_sema_chain_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .irq        (irq),
        .chan_busy  (chan_busy)
    );

    // memory model: registered read, data one cycle after request
    always_ff @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= mem[mem_addr[6:2]];
            req_log[n_req[5:0]] <= mem_addr;
            n_req <= n_req + 1;
            if (mem_addr[3:0] == 4'h0) n_starts <= n_starts + 1;
        end
    end

    // stimulus table: pointer, semaphore add, expected fetch count, count and pointer after
    localparam int NV = 6;
    localparam logic [31:0] V_NXT   [NV] = '{32'h00, 32'h00, 32'h20, 32'h40, 32'h40, 32'h30};
    localparam logic [31:0] V_ADD   [NV] = '{4, 2, 1, 1, 3, 0};
    localparam int          V_START [NV] = '{4, 2, 1, 2, 3, 0};
    localparam logic [31:0] V_SEMA  [NV] = '{0, 0, 0, 0, 1, 1};
    localparam logic [31:0] V_PTR   [NV] = '{32'h30, 32'h20, 32'h30, 32'h60, 32'h60, 32'h30};

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3000 && quiet < 4; i++) begin
            @(negedge clk);
            if (chan_busy) quiet = 0;
            else quiet++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not end");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int s0, r0, bc;

        for (int i = 0; i < 32; i++) mem[i] = '0;
        // D0..D3 at 0x00..0x30, D4..D6 at 0x40..0x60; bits 31:16 carry an ignored count
        mem[0]  = 32'h10; mem[1]  = 32'h0010_0007; mem[2]  = 32'h1000;
        mem[4]  = 32'h20; mem[5]  = 32'h0020_0003; mem[6]  = 32'h1100;
        mem[8]  = 32'h30; mem[9]  = 32'h0030_0003; mem[10] = 32'h1200;
        mem[12] = 32'h00; mem[13] = 32'h0040_0006; mem[14] = 32'h1300;
        mem[16] = 32'h50; mem[17] = 32'h0001_0001; mem[18] = 32'h1400;
        mem[20] = 32'h60; mem[21] = 32'h0002_0003; mem[22] = 32'h1500;
        mem[24] = 32'h70; mem[25] = 32'h0003_0002; mem[26] = 32'h1600;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(3'd0, v); chk("R10 ctrl after reset", v, 32'h0);
        rd(3'd4, v); chk("R10 count after reset", v, 32'h0);
        rd(3'd3, v); chk("R10 pointer after reset", v, 32'h0);
        chk("R10 outputs after reset", {29'd0, irq, mem_req, chan_busy}, 32'h0);

        wr(3'd1, 32'h4);  // enable interrupt

        // table walk: R1 R2 R3 R4
        for (int k = 0; k < NV; k++) begin
            s0 = n_starts;
            wr(3'd3, V_NXT[k]);
            wr(3'd4, V_ADD[k]);
            wait_idle();
            chk($sformatf("R1 R2 fetches vec %0d", k), 32'(n_starts - s0), 32'(V_START[k]));
            rd(3'd4, v); chk($sformatf("R2 R4 count vec %0d", k), v, V_SEMA[k]);
            rd(3'd3, v); chk($sformatf("R3 pointer vec %0d", k), v, V_PTR[k]);
        end

        // R7 status and enable gating, R6 alias zero bits untouched
        rd(3'd0, v); chk("R7 status raised", v, 32'h0C);
        chk("R7 irq with enable", {31'd0, irq}, 32'h1);
        wr(3'd2, 32'h4);
        rd(3'd0, v); chk("R6 clear leaves status", v, 32'h08);
        chk("R7 irq masked", {31'd0, irq}, 32'h0);
        wr(3'd1, 32'h4);
        wr(3'd2, 32'h8);
        rd(3'd0, v); chk("R6 R7 status cleared, enable kept", v, 32'h04);
        chk("R7 irq after status clear", {31'd0, irq}, 32'h0);

        // R8 reset with leftover count, then reset mid-run
        wr(3'd1, 32'h2);
        repeat (2) @(negedge clk);
        rd(3'd4, v); chk("R8 count cleared", v, 32'h0);
        rd(3'd0, v); chk("R8 reset bit self-clears", v, 32'h04);
        wr(3'd3, 32'h40);
        wr(3'd4, 32'd3);
        repeat (8) @(negedge clk);
        wr(3'd1, 32'h2);
        @(negedge clk);
        chk("R8 busy after reset", {31'd0, chan_busy}, 32'h0);
        s0 = n_starts;
        repeat (30) @(negedge clk);
        chk("R8 no restart", 32'(n_starts - s0), 32'h0);
        rd(3'd4, v); chk("R8 count zero after mid-run reset", v, 32'h0);

        // R5 gate holds idle, then releases
        wr(3'd1, 32'h1);
        s0 = n_starts;
        wr(3'd3, 32'h00);
        wr(3'd4, 32'd2);
        repeat (30) @(negedge clk);
        chk("R5 gated fetches", 32'(n_starts - s0), 32'h0);
        chk("R5 gated busy", {31'd0, chan_busy}, 32'h0);
        wr(3'd2, 32'h1);
        wait_idle();
        chk("R5 release fetches", 32'(n_starts - s0), 32'd2);
        rd(3'd3, v); chk("R5 pointer after release", v, 32'h20);

        // R5 gate during a data phase
        wr(3'd2, 32'h8);
        wr(3'd3, 32'h00);
        wr(3'd4, 32'd1);
        repeat (5) @(negedge clk);
        wr(3'd1, 32'h1);
        @(negedge clk);
        chk("R5 halt busy", {31'd0, chan_busy}, 32'h0);
        rd(3'd4, v); chk("R5 count kept", v, 32'h1);
        rd(3'd3, v); chk("R5 pointer kept", v, 32'h0);
        rd(3'd0, v); chk("R5 R7 no status on abort", v, 32'h05);
        s0 = n_starts;
        wr(3'd2, 32'h1);
        wait_idle();
        chk("R5 rerun fetches", 32'(n_starts - s0), 32'd1);
        rd(3'd4, v); chk("R5 rerun count", v, 32'h0);
        rd(3'd3, v); chk("R5 rerun pointer", v, 32'h10);
        rd(3'd0, v); chk("R7 status on rerun", v, 32'h0C);

        // R4 add swept across a running command
        for (int d = 0; d < 12; d++) begin
            s0 = n_starts;
            wr(3'd3, 32'h00);
            wr(3'd4, 32'd1);
            repeat (d) @(negedge clk);
            wr(3'd4, 32'd3);
            wait_idle();
            chk($sformatf("R4 fetches delay %0d", d), 32'(n_starts - s0), 32'd4);
            rd(3'd4, v); chk($sformatf("R4 net count delay %0d", d), v, 32'h0);
        end

        // R9 fetch order and busy length of one command
        r0 = n_req;
        wr(3'd3, 32'h60);
        bc = 0;
        @(negedge clk);
        host_addr = 3'd4; host_wdata = 32'd1; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (chan_busy) bc++;
        end
        chk("R9 busy cycles", 32'(bc), 32'(4 + XCYC + 1));
        chk("R9 requests", 32'(n_req - r0), 32'd3);
        chk("R9 word0 address", req_log[r0[5:0]], 32'h60);
        chk("R9 word1 address", req_log[6'(r0 + 1)], 32'h64);
        chk("R9 word2 address", req_log[6'(r0 + 2)], 32'h68);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule